// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This block executes one instruction class: round a floating-point register value to an integral value in the same format. It decodes a 32-bit instruction word, drives a read index into a register file of 32-bit slots, takes the operand returned in the same cycle and, one clock later, presents a write-back of the rounded result together with its destination slot index. A single-precision operation reads and writes one slot. A double-precision operation reads and writes an even/odd slot pair. The even slot holds the low 32 bits of the 64-bit value.

The rounding direction is encoded in the instruction itself rather than taken from a control register. Four directions are available: nearest with ties away from zero, nearest with ties to even, toward plus infinity and toward minus infinity. The rounding is done by masking the fraction bits below the binary point and, when the direction asks for it, adding one unit at the integer position. The unit never reports inexact. A signalling NaN operand raises an invalid-operation flag and produces its quietened form. A word that does not carry this instruction's fixed fields is reported as illegal, and in that case nothing is written back.

Top module: `fp_rint_unit`

## Requirements
- R1: A word is accepted only when bits 31..24 are 0xFE, bit 23 is 1, bits 21..18 are 1110, bits 11..9 are 101, bits 7..6 are 01 and bit 4 is 0. A valid word that misses any of these fields sets `illegal` and clears `wr_en` on the next cycle, and no write takes place.
- R2: Bits 17..16 select the rounding direction: 00 is nearest with ties away from zero, 01 is nearest with ties to even, 10 is toward plus infinity and 11 is toward minus infinity.
- R3: Bit 8 selects the format: 1 is double precision and 0 is single precision. `wr_dbl` reports the format of the write.
- R4: In single precision the source slot is {bits 3..0, bit 5} and the destination slot is {bits 15..12, bit 22}.
- R5: In double precision the source pair base is {bit 5, bits 3..0, 0} and the destination pair base is {bit 22, bits 15..12, 0}. The slot at base holds bits 31..0 and slot base+1 holds bits 63..32.
- R6: A finite value whose unbiased exponent is at least the fraction width (23 or 52) is returned unchanged. Infinities and zeros are also returned unchanged.
- R7: A signalling NaN returns with its top fraction bit set and raises `invalid_op`. A quiet NaN returns unchanged and does not raise `invalid_op`. No other case raises `invalid_op`.
- R8: A result of magnitude zero keeps the sign of the operand, for example -0.3 rounded toward plus infinity gives -0.0. A magnitude below one rounds to 0 or to 1.0 of the operand's sign, as the direction dictates.
- R9: When rounding up carries out of the fraction, the exponent is incremented and the fraction is zero (for example 1.75 becomes 2.0).
- R10: The result, `wr_en` and `illegal` are registered and appear one cycle after `insn_valid`. After reset, `wr_en`, `illegal` and `invalid_op` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| src_idx | output | 6 | Register-file read index (pair base for double precision) |
| src_lo | input | 32 | Slot contents at src_idx |
| src_hi | input | 32 | Slot contents at src_idx+1 |
| wr_en | output | 1 | Write-back strobe |
| wr_dbl | output | 1 | Write covers a slot pair |
| wr_idx | output | 6 | Destination slot index (pair base for double precision) |
| wr_lo | output | 32 | Result for slot wr_idx |
| wr_hi | output | 32 | Result for slot wr_idx+1 (double precision only) |
| invalid_op | output | 1 | Invalid-operation flag (signalling NaN operand) |
| illegal | output | 1 | Instruction word is not this instruction |

## Verification
The bench builds the unit with its default format parameters: an 8-bit exponent with a 23-bit fraction, and an 11-bit exponent with a 52-bit fraction. With these widths every masking position from the unit bit down to the lowest fraction bit can be reached. So can the exponent thresholds at which values stop needing rounding, exact halfway ties on both odd and even integers, carries that bump the exponent, and sub-one magnitudes including denormals. The expected results come from real-number floor and ceiling arithmetic on the decoded value. This is independent of the bit masking the design uses.

// File: rtl/fp_rint_pkg.sv
package fp_rint_pkg;

    localparam int SLOT_W = 32;
    localparam int IDX_W  = 6;
    localparam int SP_EXP = 8;
    localparam int SP_MAN = 23;
    localparam int DP_EXP = 11;
    localparam int DP_MAN = 52;

    typedef enum logic [1:0] {
        RM_TIE_AWAY = 2'b00,
        RM_TIE_EVEN = 2'b01,
        RM_UP       = 2'b10,
        RM_DOWN     = 2'b11
    } rmode_e;

    typedef struct packed {
        logic             hit;
        logic             dbl;
        rmode_e           mode;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
    } dec_t;

    typedef struct packed {
        logic              wr_en;
        logic              wr_dbl;
        logic [IDX_W-1:0]  wr_idx;
        logic [SLOT_W-1:0] wr_lo;
        logic [SLOT_W-1:0] wr_hi;
        logic              inv;
        logic              illegal;
    } state_t;

endpackage

// File: rtl/fp_rint_decode.sv
module fp_rint_decode
    import fp_rint_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);
    always_comb begin
        dec.hit  = (insn[31:24] == 8'hFE) && insn[23] &&
                   (insn[21:18] == 4'b1110) && (insn[11:9] == 3'b101) &&
                   (insn[7:6] == 2'b01) && !insn[4];
        dec.dbl  = insn[8];
        dec.mode = rmode_e'(insn[17:16]);
        if (insn[8]) begin
            dec.src = {insn[5], insn[3:0], 1'b0};
            dec.dst = {insn[22], insn[15:12], 1'b0};
        end else begin
            dec.src = {1'b0, insn[3:0], insn[5]};
            dec.dst = {1'b0, insn[15:12], insn[22]};
        end
    end
endmodule

// File: rtl/fp_rint_core.sv
module fp_rint_core
    import fp_rint_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] op,
    input  rmode_e       mode,
    output logic [W-1:0] res,
    output logic         inv
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] fr, mask, rem, kept, half;
    logic [MAN_W:0]   sum;
    logic             odd, inc;
    int               nfr;

    always_comb begin
        sgn  = op[W-1];
        ex   = op[W-2:MAN_W];
        fr   = op[MAN_W-1:0];
        res  = op;
        inv  = 1'b0;
        nfr  = 0;
        mask = '0;
        rem  = '0;
        kept = '0;
        half = '0;
        sum  = '0;
        odd  = 1'b0;
        inc  = 1'b0;
        if (&ex) begin
            // NaN or infinity: only a signalling NaN changes
            if ((|fr) && !fr[MAN_W-1]) begin
                res[MAN_W-1] = 1'b1;
                inv          = 1'b1;
            end
        end else if (int'(ex) >= BIAS + MAN_W) begin
            res = op;
        end else if (int'(ex) < BIAS) begin
            // magnitude below one: result is 0 or 1.0
            if (ex != '0 || fr != '0) begin
                case (mode)
                    RM_TIE_AWAY: inc = (int'(ex) == BIAS - 1);
                    RM_TIE_EVEN: inc = (int'(ex) == BIAS - 1) && (fr != '0);
                    RM_UP:       inc = !sgn;
                    default:     inc = sgn;
                endcase
                res = inc ? {sgn, EXP_W'(BIAS), {MAN_W{1'b0}}}
                          : {sgn, {(W-1){1'b0}}};
            end
        end else begin
            nfr  = MAN_W - (int'(ex) - BIAS);
            mask = {MAN_W{1'b1}} << nfr;
            kept = fr & mask;
            rem  = fr & ~mask;
            half = MAN_W'(1) << (nfr - 1);
            odd  = (nfr == MAN_W) || (|(fr & (MAN_W'(1) << nfr)));
            case (mode)
                RM_TIE_AWAY: inc = (rem >= half);
                RM_TIE_EVEN: inc = (rem > half) || ((rem == half) && odd);
                RM_UP:       inc = !sgn && (|rem);
                default:     inc = sgn && (|rem);
            endcase
            sum = {1'b0, kept} + ((MAN_W+1)'(1) << nfr);
            if (!inc)
                res = {sgn, ex, kept};
            else if (sum[MAN_W])
                res = {sgn, ex + 1'b1, {MAN_W{1'b0}}};
            else
                res = {sgn, ex, sum[MAN_W-1:0]};
        end
    end
endmodule

// File: rtl/fp_rint_unit.sv
module fp_rint_unit
    import fp_rint_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        insn_valid,
    input  logic [31:0] insn,
    output logic [5:0]  src_idx,
    input  logic [31:0] src_lo,
    input  logic [31:0] src_hi,
    output logic        wr_en,
    output logic        wr_dbl,
    output logic [5:0]  wr_idx,
    output logic [31:0] wr_lo,
    output logic [31:0] wr_hi,
    output logic        invalid_op,
    output logic        illegal
);
    localparam int SP_W = 1 + SP_EXP + SP_MAN;
    localparam int DP_W = 1 + DP_EXP + DP_MAN;

    dec_t            dec;
    logic [SP_W-1:0] sp_res;
    logic [DP_W-1:0] dp_res;
    logic            sp_inv, dp_inv;
    state_t          state_d, state_q;

    fp_rint_decode u_dec (.insn(insn), .dec(dec));

    fp_rint_core #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp (
        .op(src_lo), .mode(dec.mode), .res(sp_res), .inv(sp_inv));

    fp_rint_core #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp (
        .op({src_hi, src_lo}), .mode(dec.mode), .res(dp_res), .inv(dp_inv));

    assign src_idx = dec.src;

    always_comb begin
        state_d         = '0;
        state_d.wr_en   = insn_valid && dec.hit;
        state_d.illegal = insn_valid && !dec.hit;
        state_d.wr_dbl  = dec.dbl;
        state_d.wr_idx  = dec.dst;
        if (dec.dbl) begin
            {state_d.wr_hi, state_d.wr_lo} = dp_res;
            state_d.inv = state_d.wr_en && dp_inv;
        end else begin
            state_d.wr_lo = sp_res;
            state_d.inv   = state_d.wr_en && sp_inv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wr_en      = state_q.wr_en;
    assign wr_dbl     = state_q.wr_dbl;
    assign wr_idx     = state_q.wr_idx;
    assign wr_lo      = state_q.wr_lo;
    assign wr_hi      = state_q.wr_hi;
    assign invalid_op = state_q.inv;
    assign illegal    = state_q.illegal;

    // R1
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && illegal));

    // R10
    write_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || illegal) |-> $past(insn_valid));

    // R5
    pair_base_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dbl) |-> !wr_idx[0]);

    // R7
    invalid_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_op |-> wr_en);

    // R8
    sp_sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_dbl) |-> (wr_lo[31] == $past(src_lo[31])));

    // R8
    dp_sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dbl) |-> (wr_hi[31] == $past(src_hi[31])));

endmodule

// File: tb/fp_rint_unit_tb.sv
module fp_rint_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [5:0]  src_idx;
    logic [31:0] src_lo, src_hi;
    logic        wr_en, wr_dbl, illegal, invalid_op;
    logic [5:0]  wr_idx;
    logic [31:0] wr_lo, wr_hi;
    logic [31:0] rf [64];
    int          n_chk = 0;
    int          n_fail = 0;
    logic        exp_wr_q = 1'b0;
    logic        exp_ill_q = 1'b0;

    always #4 clk = ~clk;

    assign src_lo = rf[src_idx];
    assign src_hi = rf[src_idx + 6'd1];

    fp_rint_unit u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .src_idx(src_idx), .src_lo(src_lo), .src_hi(src_hi),
        .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .invalid_op(invalid_op), .illegal(illegal));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic bit legal_ref(logic [31:0] w);
        return w[31:24] == 8'hFE && w[23] == 1'b1 && w[21:18] == 4'hE &&
               w[11:9] == 3'd5 && w[7:6] == 2'd1 && w[4] == 1'b0;
    endfunction

    function automatic logic [31:0] mk(bit dbl, logic [1:0] m, int d, int s);
        logic [31:0] w;
        w = 32'hFE800000 | 32'h00380000 | 32'h00000A00 | 32'h00000040;
        w[8] = dbl;
        w[17:16] = m;
        w[15:12] = 4'(d >> 1);
        w[3:0] = 4'(s >> 1);
        if (dbl) begin
            w[22] = 1'(d >> 5);
            w[5] = 1'(s >> 5);
        end else begin
            w[22] = 1'(d);
            w[5] = 1'(s);
        end
        return w;
    endfunction

    // rounding of a finite double of magnitude below 2^52, in real arithmetic
    function automatic logic [63:0] round_real(logic [63:0] x, logic [1:0] m);
        real a, f, d, r;
        logic [63:0] o;
        a = $bitstoreal({1'b0, x[62:0]});
        f = $floor(a);
        d = a - f;
        case (m)
            2'd0: r = (d >= 0.5) ? f + 1.0 : f;
            2'd1: begin
                if (d > 0.5) r = f + 1.0;
                else if (d < 0.5) r = f;
                else r = ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
            end
            2'd2: r = x[63] ? f : $ceil(a);
            default: r = x[63] ? $ceil(a) : f;
        endcase
        o = $realtobits(r);
        o[63] = x[63];
        return o;
    endfunction

    function automatic logic [64:0] ref_dbl(logic [63:0] x, logic [1:0] m);
        if (x[62:52] == 11'h7FF) begin
            if (x[51:0] != 0 && !x[51]) return {1'b1, x | 64'h0008_0000_0000_0000};
            return {1'b0, x};
        end
        if (x[62:52] >= 11'd1075) return {1'b0, x};
        return {1'b0, round_real(x, m)};
    endfunction

    function automatic logic [32:0] ref_sgl(logic [31:0] x, logic [1:0] m);
        logic [63:0] r;
        if (x[30:23] == 8'hFF) begin
            if (x[22:0] != 0 && !x[22]) return {1'b1, x | 32'h0040_0000};
            return {1'b0, x};
        end
        if (x[30:23] >= 8'd150) return {1'b0, x};
        if (x[30:23] == 8'd0) begin
            if (x[22:0] == 0) return {1'b0, x};
            if ((m == 2'd2 && !x[31]) || (m == 2'd3 && x[31]))
                return {1'b0, x[31], 8'd127, 23'd0};
            return {1'b0, x[31], 31'd0};
        end
        r = round_real({x[31], 11'(x[30:23]) + 11'd896, x[22:0], 29'd0}, m);
        if (r[62:0] == 0) return {1'b0, x[31], 31'd0};
        return {1'b0, r[63], 8'(r[62:52] - 11'd896), r[51:29]};
    endfunction

    always @(posedge clk) begin
        exp_wr_q  <= rst_n && insn_valid && legal_ref(insn);
        exp_ill_q <= rst_n && insn_valid && !legal_ref(insn);
    end

    // R10: strobes compared on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk(wr_en == exp_wr_q, "R10 wr_en", 64'(wr_en), 64'(exp_wr_q));
            chk(illegal == exp_ill_q, "R1 illegal", 64'(illegal), 64'(exp_ill_q));
        end
    end

    task automatic op_sgl(input logic [1:0] m, input int d, input int s,
                          input logic [31:0] x, input string tag);
        logic [32:0] e;
        @(negedge clk);
        rf[s] = x;
        insn = mk(1'b0, m, d, s);
        insn_valid = 1'b1;
        e = ref_sgl(x, m);
        @(negedge clk);
        insn_valid = 1'b0;
        chk(wr_en && !wr_dbl && wr_idx == 6'(d), {tag, " R4 R3 index"},
            {57'd0, wr_dbl, wr_idx}, {58'd0, 6'(d)});
        chk(wr_lo == e[31:0], {tag, " R2 value"}, 64'(wr_lo), 64'(e[31:0]));
        chk(invalid_op == e[32], {tag, " R7 invalid"}, 64'(invalid_op), 64'(e[32]));
    endtask

    task automatic op_dbl(input logic [1:0] m, input int d, input int s,
                          input logic [63:0] x, input string tag);
        logic [64:0] e;
        @(negedge clk);
        rf[s] = x[31:0];
        rf[s+1] = x[63:32];
        insn = mk(1'b1, m, d, s);
        insn_valid = 1'b1;
        e = ref_dbl(x, m);
        @(negedge clk);
        insn_valid = 1'b0;
        chk(wr_en && wr_dbl && wr_idx == 6'(d), {tag, " R5 R3 index"},
            {57'd0, wr_dbl, wr_idx}, {57'd1, 6'(d)});
        chk({wr_hi, wr_lo} == e[63:0], {tag, " R2 value"}, {wr_hi, wr_lo}, e[63:0]);
        chk(invalid_op == e[64], {tag, " R7 invalid"}, 64'(invalid_op), 64'(e[64]));
    endtask

    task automatic bad_word(input logic [31:0] w, input string tag);
        @(negedge clk);
        insn = w;
        insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
        chk(illegal && !wr_en, tag, {62'd0, illegal, wr_en}, 64'd2);
    endtask

    initial begin
        fork
            begin
                #(8 * 150000);
                n_fail++;
                n_chk++;
                $display("FAIL watchdog expired actual=hung expected=done");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        join_none
    end

    initial begin
        for (int i = 0; i < 64; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!wr_en && !illegal && !invalid_op, "R10 reset",
            {61'd0, wr_en, illegal, invalid_op}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 decode
        bad_word(mk(1'b0, 2'd0, 1, 2) & ~32'h0080_0000, "R1 bit23 clear");
        bad_word(mk(1'b0, 2'd0, 1, 2) | 32'h0000_0010, "R1 bit4 set");
        bad_word(mk(1'b1, 2'd1, 2, 4) ^ 32'h0100_0000, "R1 top byte");
        bad_word(mk(1'b0, 2'd2, 3, 5) | 32'h0000_0080, "R1 bit7 set");

        // R2 all directions on ties and non-ties, single and double
        for (int m = 0; m < 4; m++) begin
            op_sgl(2'(m), 7, 9, 32'h4020_0000, "R2 sgl 2.5");
            op_sgl(2'(m), 7, 9, 32'hC020_0000, "R2 sgl -2.5");
            op_sgl(2'(m), 7, 9, 32'h4060_0000, "R2 sgl 3.5");
            op_dbl(2'(m), 10, 20, $realtobits(-3.5), "R2 dbl -3.5");
            op_dbl(2'(m), 10, 20, $realtobits(4.25), "R2 dbl 4.25");
        end

        // R4 single indices
        op_sgl(2'd1, 21, 11, 32'h3FC0_0000, "R4 slots 21/11");
        op_sgl(2'd1, 30, 31, 32'h4120_0000, "R4 slots 30/31");
        // R5 pair indices
        op_dbl(2'd0, 38, 42, $realtobits(7.5), "R5 pair 38/42");
        op_dbl(2'd3, 62, 0, $realtobits(-1.25), "R5 pair 62/0");

        // R6 pass-through
        op_sgl(2'd2, 1, 2, 32'h4E80_0000, "R6 sgl 2^30");
        op_sgl(2'd3, 1, 2, 32'h4B00_0001, "R6 sgl 2^23+1");
        op_sgl(2'd0, 1, 2, 32'hFF80_0000, "R6 sgl -inf");
        op_dbl(2'd2, 4, 6, $realtobits(1.0e20), "R6 dbl 1e20");
        op_dbl(2'd1, 4, 6, 64'h7FF0_0000_0000_0000, "R6 dbl inf");

        // R7 NaNs
        op_sgl(2'd0, 3, 4, 32'h7F80_0001, "R7 sgl snan");
        op_sgl(2'd0, 3, 4, 32'hFFC0_0005, "R7 sgl qnan");
        op_dbl(2'd2, 8, 12, 64'hFFF0_0000_0000_0003, "R7 dbl snan");
        op_dbl(2'd2, 8, 12, 64'h7FF8_0000_0000_0000, "R7 dbl qnan");

        // R8 small magnitudes and sign of zero
        op_sgl(2'd2, 5, 6, 32'hBE99_999A, "R8 sgl -0.3 up");
        op_sgl(2'd3, 5, 6, 32'h3E99_999A, "R8 sgl 0.3 down");
        op_sgl(2'd0, 5, 6, 32'h3F00_0000, "R8 sgl 0.5 away");
        op_sgl(2'd1, 5, 6, 32'hBF00_0000, "R8 sgl -0.5 even");
        op_sgl(2'd3, 5, 6, 32'h8000_0001, "R8 sgl -denorm down");
        op_sgl(2'd1, 5, 6, 32'h8000_0000, "R8 sgl -0");
        op_dbl(2'd2, 14, 16, $realtobits(-0.3), "R8 dbl -0.3 up");

        // R9 carry into exponent
        op_sgl(2'd0, 5, 6, 32'h3FE0_0000, "R9 sgl 1.75");
        op_sgl(2'd2, 5, 6, 32'h4B7F_FFFF, "R9 sgl near 2^24");
        op_dbl(2'd1, 14, 16, $realtobits(3.75), "R9 dbl 3.75");

        // sweeps over many exponents
        for (int i = 0; i < 40; i++) begin
            for (int m = 0; m < 4; m++) begin
                op_sgl(2'(m), i % 32, (i + 3) % 32,
                       32'h3E00_0000 + 32'(i) * 32'h0028_0123 + ((i % 2) == 1 ? 32'h8000_0000 : 32'h0),
                       "R2 sgl sweep");
                op_dbl(2'(m), (2 * i) % 64, (2 * i + 6) % 64,
                       $realtobits(real'(i) * 0.25 - 5.0), "R2 dbl sweep");
            end
        end

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule